// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register core of a general-purpose I/O expander with a configurable pin count. A host reaches it through a byte-wide register port, with a write strobe, an address and write data, and a read data bus that follows the address in the same cycle. Through this port the host configures each pin as input or output, sets output values, reads back pad levels, enables interrupts per pin and acknowledges pending events. Each register byte serves eight pins. The bit position within the byte is the pin number modulo 8, and the byte index is the pin number divided by 8.

The registers are arranged in groups by function. Each group takes a power-of-two number of bytes, found by rounding the pin count up to a power of two. A 48-pin instance therefore lays out its groups as a 64-pin one would. Pad inputs pass through a two-stage synchroniser. Any change of a synchronised level sets a sticky status bit. One interrupt line tells the host that an enabled status bit is pending.

Top module: `gpx_regfile`

## Requirements
- R1: The byte address is (group << S) + byte index, with S = clog2(NUM_PINS) - 3. The group codes are: direction 0, level 1, interrupt enable 2, status 3. Pin p is bit p mod 8 of byte p / 8 in every group.
- R2: A direction bit of 1 drives the matching `pad_oe` bit high and makes the pin an output. A direction bit of 0 makes the pin an input. A direction byte reads back exactly the value written to it.
- R3: A write to the level group stores the output value of each pin in that byte. `pad_out` shows the stored values in the cycle after the write.
- R4: A read of the level group returns `pad_in` after a two-flop synchroniser. A change made between two clock edges shows up after the second following rising edge.
- R5: After reset, the direction, output, interrupt-enable and status registers are all 0. `pad_oe`, `pad_out` and `irq` are all low.
- R6: A status bit is set on any change, rising or falling, of its pin's synchronised level. This happens on the third rising edge after the pad changes. The bit stays set until the host clears it, and it is captured whether or not its interrupt is enabled.
- R7: Writing 1 to a status bit clears it, and status bits written with 0 keep their value. If a clear and a new capture land on the same bit in the same cycle, the capture wins.
- R8: `irq` is high in exactly those cycles in which some pin has both its status bit and its enable bit set.
- R9: Group codes 4 to 7, and byte indices at or above ceil(NUM_PINS/8), read as 0x00, and writes to them change nothing.
- R10: Pad levels present during reset, and during the first three cycles after reset, do not set any status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address (group and byte index) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables, 1 means drive |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench uses a 48-pin instance, so byte indices 6 and 7 of each group have no pins. Writes to those bytes and to the spare group codes must read back as zero. A decoder that did not bound the byte index would store and return the written value there. The bench times a pad change edge by edge, which separates a design with too few or too many synchroniser stages from a correct one. It also lands a status acknowledge in the same cycle as a new capture, so a design where the clear wins would lose the event. Finally, it holds pads high through reset, so a design without the start-up guard would report a spurious status bit on the first read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // Function group held in the upper address bits.
    typedef enum logic [2:0] {
        GRP_DIR   = 3'd0,
        GRP_LVL   = 3'd1,
        GRP_IEN   = 3'd2,
        GRP_IST   = 3'd3,
        GRP_SPARE = 3'd4
    } gpx_grp_e;

    localparam int GRP_W = 3;

    // Byte-index width: pin count rounded up to a power of two, over eight.
    function automatic int bank_shift(input int pins);
        return ($clog2(pins) > 3) ? ($clog2(pins) - 3) : 0;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;

endmodule

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int SHIFT  = 3,
    parameter int BYTES  = 6,
    parameter int ADDR_W = SHIFT + GRP_W,
    parameter int IDX_W  = (SHIFT > 0) ? SHIFT : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        sel,
    output logic [IDX_W-1:0]  idx
);

    logic [GRP_W-1:0] grp;
    logic             in_range;

    assign grp = addr[ADDR_W-1 -: GRP_W];

    generate
        if (SHIFT > 0) begin : g_idx
            assign idx = addr[SHIFT-1:0];
        end else begin : g_noidx
            assign idx = '0;
        end
    endgenerate

    // Byte indices past the last populated byte are not decoded.
    assign in_range = ({1'b0, idx} < (IDX_W + 1)'(BYTES));

    always_comb begin
        sel = '0;
        if (in_range) begin
            case (gpx_grp_e'(grp))
                GRP_DIR: sel[0] = 1'b1;
                GRP_LVL: sel[1] = 1'b1;
                GRP_IEN: sel[2] = 1'b1;
                GRP_IST: sel[3] = 1'b1;
                default: sel = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux #(
    parameter int PADW  = 64,
    parameter int IDX_W = 3
) (
    input  logic [3:0]       sel,
    input  logic [IDX_W-1:0] idx,
    input  logic [PADW-1:0]  v_dir,
    input  logic [PADW-1:0]  v_lvl,
    input  logic [PADW-1:0]  v_ien,
    input  logic [PADW-1:0]  v_ist,
    output logic [7:0]       rdata
);

    logic [IDX_W+2:0] ofs;

    assign ofs = {idx, 3'b000};

    // AND-OR mux: the decoder gives at most one select.
    always_comb begin
        rdata = ({8{sel[0]}} & v_dir[ofs +: 8])
              | ({8{sel[1]}} & v_lvl[ofs +: 8])
              | ({8{sel[2]}} & v_ien[ofs +: 8])
              | ({8{sel[3]}} & v_ist[ofs +: 8]);
    end

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter  int NUM_PINS = 48,
    localparam int SHIFT    = bank_shift(NUM_PINS),
    localparam int ADDR_W   = SHIFT + GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int REGS  = 1 << SHIFT;
    localparam int PADW  = REGS * 8;
    localparam int BYTES = (NUM_PINS + 7) / 8;
    localparam int IDX_W = (SHIFT > 0) ? SHIFT : 1;

    typedef struct packed {
        logic [PADW-1:0] dir;
        logic [PADW-1:0] outv;
        logic [PADW-1:0] ien;
        logic [PADW-1:0] ists;
        logic [PADW-1:0] prev;
        logic [1:0]      warm;
    } state_t;

    state_t          st_d, st_q;
    logic [PADW-1:0] pin_mask;
    logic [PADW-1:0] pad_wide;
    logic [PADW-1:0] lvl_s;
    logic [3:0]      sel;
    logic [IDX_W-1:0] byte_idx;
    logic [PADW-1:0] wmask;
    logic [PADW-1:0] wbits;
    logic [PADW-1:0] clr;
    logic [PADW-1:0] chg;

    // Bits of the padded vectors that stand for real pins.
    generate
        for (genvar i = 0; i < PADW; i++) begin : g_mask
            assign pin_mask[i] = (i < NUM_PINS);
        end
        if (PADW > NUM_PINS) begin : g_pad
            assign pad_wide = {{(PADW - NUM_PINS){1'b0}}, pad_in};
        end else begin : g_nopad
            assign pad_wide = pad_in;
        end
    endgenerate

    gpx_sync #(.W(PADW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_wide),
        .q     (lvl_s)
    );

    gpx_decode #(
        .SHIFT  (SHIFT),
        .BYTES  (BYTES),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr (reg_addr),
        .sel  (sel),
        .idx  (byte_idx)
    );

    always_comb begin
        st_d  = st_q;
        wmask = '0;
        wbits = '0;
        for (int b = 0; b < REGS; b++) begin
            wbits[b*8 +: 8] = reg_wdata;
            if (byte_idx == IDX_W'(b)) begin
                wmask[b*8 +: 8] = 8'hFF;
            end
        end
        wmask = wmask & pin_mask;

        if (reg_we && sel[0]) begin
            st_d.dir = (st_q.dir & ~wmask) | (wbits & wmask);
        end
        if (reg_we && sel[1]) begin
            st_d.outv = (st_q.outv & ~wmask) | (wbits & wmask);
        end
        if (reg_we && sel[2]) begin
            st_d.ien = (st_q.ien & ~wmask) | (wbits & wmask);
        end

        clr = (reg_we && sel[3]) ? (wbits & wmask) : '0;
        // Capture starts once prev follows a settled synchroniser.
        chg = (st_q.warm == 2'd3) ? ((lvl_s ^ st_q.prev) & pin_mask) : '0;
        st_d.ists = (st_q.ists & ~clr) | chg;

        st_d.prev = lvl_s;
        if (st_q.warm != 2'd3) begin
            st_d.warm = st_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    gpx_rdmux #(.PADW(PADW), .IDX_W(IDX_W)) u_rd (
        .sel   (sel),
        .idx   (byte_idx),
        .v_dir (st_q.dir),
        .v_lvl (lvl_s & pin_mask),
        .v_ien (st_q.ien),
        .v_ist (st_q.ists),
        .rdata (reg_rdata)
    );

    assign pad_oe  = st_q.dir[NUM_PINS-1:0];
    assign pad_out = st_q.outv[NUM_PINS-1:0];
    assign irq     = |(st_q.ists & st_q.ien);

endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 6,
    parameter int PADW     = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [7:0]          reg_rdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                irq,
    input logic [PADW-1:0]     ists
);

    logic [2:0] grp;
    assign grp = reg_addr[ADDR_W-1 -: 3];

    // R2: output enables move only on a direction write
    a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && grp == 3'd0) |=> $stable(pad_oe));

    // R3: output values move only on a level write
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && grp == 3'd1) |=> $stable(pad_out));

    // R6: status bits never drop without a status write
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && grp == 3'd3) |=> (($past(ists) & ~ists) == '0));

    // R8: a new request needs a register write or a fresh capture
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(reg_we) || ((ists & ~$past(ists)) != '0)));

    // R9: spare group codes read as zero
    a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (grp > 3'd3) |-> (reg_rdata == 8'h00));

endmodule

bind gpx_regfile gpx_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .PADW     (PADW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq),
    .ists      (st_q.ists)
);

// File: tb/sim_gpx_regfile.sv
`timescale 1ns/1ps
module sim_gpx_regfile;

    localparam int N = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic         irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    gpx_regfile #(.NUM_PINS(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // {req, addr, wdata, expected readback}
    localparam logic [31:0] VEC [10] = '{
        {8'd2, 8'd0,  8'hA5, 8'hA5},  // R2 direction byte 0
        {8'd2, 8'd5,  8'hFF, 8'hFF},  // R2 last populated byte
        {8'd9, 8'd6,  8'hFF, 8'h00},  // R9 byte without pins
        {8'd9, 8'd7,  8'h3C, 8'h00},  // R9 byte without pins
        {8'd1, 8'd17, 8'h3C, 8'h3C},  // R1 enable group, byte 1
        {8'd9, 8'd32, 8'h77, 8'h00},  // R9 spare group 4
        {8'd9, 8'd40, 8'h55, 8'h00},  // R9 group 5
        {8'd9, 8'd63, 8'hFF, 8'h00},  // R9 top of space
        {8'd1, 8'd17, 8'h00, 8'h00},  // R1 enable cleared
        {8'd2, 8'd2,  8'h0F, 8'h0F}   // R2 direction byte 2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [47:0] acc;
        pad_in = 48'h0000_0000_00C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) tick();

        // R5 reset state
        check("R5 pad_oe", 64'(pad_oe), 64'h0);
        check("R5 pad_out", 64'(pad_out), 64'h0);
        check("R5 irq", 64'(irq), 64'h0);
        acc = '0;
        for (int b = 0; b < 6; b++) begin
            rd(6'(16 + b), r);
            acc[b*8 +: 8] = r;
        end
        check("R5 enables", 64'(acc), 64'h0);
        // R10 pads high through reset leave status clear
        acc = '0;
        for (int b = 0; b < 6; b++) begin
            rd(6'(24 + b), r);
            acc[b*8 +: 8] = r;
        end
        check("R10 status", 64'(acc), 64'h0);
        rd(6'd8, r);
        check("R4 level byte0", 64'(r), 64'hC3);

        // Table walk
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][21:16], VEC[i][15:8]);
            rd(VEC[i][21:16], r);
            check($sformatf("R%0d vector %0d", VEC[i][31:24], i), 64'(r), 64'(VEC[i][7:0]));
        end
        check("R2 pad_oe", 64'(pad_oe), 64'hFF00_000F_00A5);
        wr(6'd0, 8'h00);
        wr(6'd2, 8'h00);
        wr(6'd5, 8'h00);
        check("R2 pad_oe cleared", 64'(pad_oe), 64'h0);

        // R3 output values
        wr(6'd10, 8'h5A);
        check("R3 pad_out", 64'(pad_out), 64'h0000_005A_0000);

        // R4 synchroniser timing, R6 rising capture
        pad_in[2] = 1'b1;
        tick();
        rd(6'd8, r);
        check("R4 level after one edge", 64'(r), 64'hC3);
        tick();
        rd(6'd8, r);
        check("R4 level after two edges", 64'(r), 64'hC7);
        rd(6'd24, r);
        check("R6 status before capture", 64'(r), 64'h00);
        tick();
        rd(6'd24, r);
        check("R6 status captured", 64'(r), 64'h04);
        check("R8 irq masked", 64'(irq), 64'h0);

        // R8 enable gating
        wr(6'd16, 8'h04);
        check("R8 irq enabled", 64'(irq), 64'h1);
        wr(6'd16, 8'h00);
        check("R8 irq disabled", 64'(irq), 64'h0);
        wr(6'd16, 8'h04);

        // R7 write-one-to-clear
        wr(6'd24, 8'h00);
        rd(6'd24, r);
        check("R7 zero write keeps", 64'(r), 64'h04);
        check("R7 irq kept", 64'(irq), 64'h1);
        wr(6'd24, 8'h04);
        rd(6'd24, r);
        check("R7 cleared", 64'(r), 64'h00);
        check("R7 irq dropped", 64'(irq), 64'h0);

        // R6 falling change
        pad_in[0] = 1'b0;
        repeat (3) tick();
        rd(6'd24, r);
        check("R6 falling capture", 64'(r), 64'h01);
        wr(6'd24, 8'h01);

        // R7 capture beats a clear in the same cycle
        pad_in[3] = 1'b1;
        tick();
        tick();
        wr(6'd24, 8'h08);
        rd(6'd24, r);
        check("R7 set wins", 64'(r), 64'h08);
        wr(6'd24, 8'h08);
        rd(6'd24, r);
        check("R7 later clear", 64'(r), 64'h00);

        // R1 pin 41 sits in byte 5, bit 1
        wr(6'd16, 8'h00);
        wr(6'd21, 8'h02);
        pad_in[41] = 1'b1;
        repeat (3) tick();
        rd(6'd29, r);
        check("R1 status pin 41", 64'(r), 64'h02);
        check("R1 irq pin 41", 64'(irq), 64'h1);
        wr(6'd29, 8'h02);
        check("R1 irq cleared", 64'(irq), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule